// File: doc/BRIEF.md
# Processor Status Flag Register

This block is the eight-bit status word of a small accumulator processor. It holds three arithmetic flags: zero, digit carry (carry out of the low nibble) and carry. It also holds two reset-cause flags and the bits that choose the data-memory bank used for direct addressing.

The register file can write the word like any other location, but not every bit obeys that write. The arithmetic flags are protected whenever the same instruction also reports ALU flag results. The two reset-cause flags are never touched by data; they move only on power-up, watchdog-clear, sleep-entry and watchdog time-out events. The bank-select pair leaves the block on its own port so that the address path can form a nine-bit direct address.

Bit layout, from bit 7 down to bit 0:

| Bit | Content |
|---|---|
| 7 | spare bank bit |
| 6:5 | bank select |
| 4 | time-out flag |
| 3 | power-down flag |
| 2 | zero |
| 1 | digit carry |
| 0 | carry |

Every update is registered and shows on `status` one clock after the inputs that cause it.

Top module: `proc_status_reg`

## Requirements
- R1: While `rstN` is low, `status[7:5]` reads 000 and `status[4:3]` reads 11; `status[2:0]` is undefined until first loaded.
- R2: A write (`wrEn`=1) with `flagUpd`=000 loads `wrData[7:5]` into bits 7:5 and `wrData[2:0]` into bits 2:0.
- R3: Bits 4 (time-out) and 3 (power-down) keep their value in any cycle with no event input active, whatever `wrEn` and `wrData` are.
- R4: A write with `flagUpd`≠000 loads `wrData[7:5]` only. Each flag bit whose `flagUpd` bit is 1 takes the matching `flagVal` bit, and each flag bit whose `flagUpd` bit is 0 holds. `flagUpd`/`flagVal` bit 2 is zero, bit 1 is digit carry and bit 0 is carry. Example: clearing the register with zero-flag-only update gives 000uu1uu.
- R5: With `wrEn`=0, each flag bit whose `flagUpd` bit is 1 takes its `flagVal` bit, and bits 7:5 hold.
- R6: The time-out bit becomes 1 after `evtPowerUp`, `evtWdtClear` or `evtSleep`. It becomes 0 after `evtTimeout` when none of those three is active in the same cycle.
- R7: The power-down bit becomes 1 after `evtPowerUp` or `evtWdtClear`. It becomes 0 after `evtSleep` alone; power-up and watchdog-clear win over sleep.
- R8: `bankSel` equals `status[6:5]` at all times. The bank values 00, 01, 10 and 11 select the 128-byte bank based at 0x000, 0x080, 0x100 and 0x180 respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| wrEn | input | 1 | Register-file write addressed to the status word |
| wrData | input | 8 | Write data |
| flagUpd | input | 3 | ALU flag update enables {zero, digit carry, carry} |
| flagVal | input | 3 | ALU flag results {zero, digit carry, carry} |
| evtPowerUp | input | 1 | Power-up event |
| evtWdtClear | input | 1 | Watchdog-clear instruction executed |
| evtSleep | input | 1 | Sleep instruction executed |
| evtTimeout | input | 1 | Watchdog time-out |
| status | output | 8 | Current status word |
| bankSel | output | 2 | Bank select for direct addressing |

## Verification
Writes are tried in four forms:
- with no flag update, which tells full data loading from masking;
- with a partial flag mask, where the held flags show that masking is per bit and not all-or-nothing;
- a clear with a zero-only update, the 000uu1uu case;
- a flag update without any write.

Events are applied alone and in conflicting pairs, so that the priority of set events over time-out and of power-up and watchdog-clear over sleep is seen. Random mixes of all inputs run against a bench model that is compared after every cycle.

// File: rtl/proc_status_pkg.sv
package proc_status_pkg;
  localparam int STAT_W  = 8;
  localparam int FLAG_W  = 3;
  localparam int BANK_W  = 2;
  localparam int BIT_PD  = 3;
  localparam int BIT_TO  = 4;
  localparam int BANK_LO = 5;
  localparam logic [STAT_W-1:0] RESET_VAL = 8'b0001_1000;

  typedef struct packed {
    logic [STAT_W-1:0] dataWe;
    logic [FLAG_W-1:0] flagLoad;
    logic              toLoad;
    logic              toVal;
    logic              pdLoad;
    logic              pdVal;
  } statStrobe_t;
endpackage

// File: rtl/proc_status_ctrl.sv
module proc_status_ctrl
  import proc_status_pkg::*;
(
  input  logic              wrEn,
  input  logic [FLAG_W-1:0] flagUpd,
  input  logic              evtPowerUp,
  input  logic              evtWdtClear,
  input  logic              evtSleep,
  input  logic              evtTimeout,
  output statStrobe_t       strobe
);
  logic flagInsn;
  assign flagInsn = |flagUpd;

  always_comb begin
    strobe = '0;
    for (int i = 0; i < STAT_W; i++) begin
      if (i == BIT_TO || i == BIT_PD)
        strobe.dataWe[i] = 1'b0;          // reset-cause bits are read-only
      else if (i < FLAG_W)
        strobe.dataWe[i] = wrEn && !flagInsn;  // flags protected during ALU update
      else
        strobe.dataWe[i] = wrEn;
    end
    strobe.flagLoad = flagUpd;
    // time-out: any set event beats a time-out
    strobe.toLoad = evtPowerUp | evtWdtClear | evtSleep | evtTimeout;
    strobe.toVal  = evtPowerUp | evtWdtClear | evtSleep;
    // power-down: power-up and watchdog-clear beat sleep
    strobe.pdLoad = evtPowerUp | evtWdtClear | evtSleep;
    strobe.pdVal  = evtPowerUp | evtWdtClear;
  end
endmodule

// File: rtl/proc_status_dp.sv
module proc_status_dp
  import proc_status_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  statStrobe_t       strobe,
  input  logic [STAT_W-1:0] wrData,
  input  logic [FLAG_W-1:0] flagVal,
  output logic [STAT_W-1:0] statusQ
);
  logic [STAT_W-1:0] statusD;

  always_comb begin
    statusD = statusQ;
    for (int i = 0; i < STAT_W; i++) begin
      if (i < FLAG_W && strobe.flagLoad[i])
        statusD[i] = flagVal[i];
      else if (strobe.dataWe[i])
        statusD[i] = wrData[i];
    end
    if (strobe.toLoad) statusD[BIT_TO] = strobe.toVal;
    if (strobe.pdLoad) statusD[BIT_PD] = strobe.pdVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusQ <= RESET_VAL;
    else       statusQ <= statusD;
  end
endmodule

// File: rtl/proc_status_reg.sv
module proc_status_reg
  import proc_status_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [STAT_W-1:0] wrData,
  input  logic [FLAG_W-1:0] flagUpd,
  input  logic [FLAG_W-1:0] flagVal,
  input  logic              evtPowerUp,
  input  logic              evtWdtClear,
  input  logic              evtSleep,
  input  logic              evtTimeout,
  output logic [STAT_W-1:0] status,
  output logic [BANK_W-1:0] bankSel
);
  statStrobe_t strobe;

  proc_status_ctrl uCtrl (
    .wrEn(wrEn), .flagUpd(flagUpd),
    .evtPowerUp(evtPowerUp), .evtWdtClear(evtWdtClear),
    .evtSleep(evtSleep), .evtTimeout(evtTimeout),
    .strobe(strobe)
  );

  proc_status_dp uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .wrData(wrData), .flagVal(flagVal), .statusQ(status)
  );

  assign bankSel = status[BANK_LO +: BANK_W];
endmodule

// File: rtl/proc_status_reg_chk.sv
module proc_status_reg_chk
  import proc_status_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [STAT_W-1:0] wrData,
  input logic [FLAG_W-1:0] flagUpd,
  input logic [FLAG_W-1:0] flagVal,
  input logic              evtPowerUp,
  input logic              evtWdtClear,
  input logic              evtSleep,
  input logic              evtTimeout,
  input logic [STAT_W-1:0] status,
  input logic [BANK_W-1:0] bankSel
);
  logic anyEvt;
  assign anyEvt = evtPowerUp | evtWdtClear | evtSleep | evtTimeout;

  always @(negedge clk)
    if (!rstN) p_reset_vals_r1: assert (status[7:3] == 5'b00011);

  p_plain_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && flagUpd == 3'b000 |=>
      status[7:5] == $past(wrData[7:5]) && status[2:0] == $past(wrData[2:0]));

  p_cause_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !anyEvt |=> $stable(status[4:3]));

  p_zero_masked_r4: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && flagUpd == 3'b100 |=>
      status[2] == $past(flagVal[2]) && status[1:0] == $past(status[1:0]));

  p_flag_only_r5: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn && flagUpd == 3'b111 |=>
      status[2:0] == $past(flagVal) && $stable(status[7:5]));

  p_timeout_r6: assert property (@(posedge clk) disable iff (!rstN)
    evtTimeout && !evtPowerUp && !evtWdtClear && !evtSleep |=> !status[4]);

  p_powerup_r6: assert property (@(posedge clk) disable iff (!rstN)
    evtPowerUp |=> status[4] && status[3]);

  p_sleep_r7: assert property (@(posedge clk) disable iff (!rstN)
    evtSleep && !evtPowerUp && !evtWdtClear |=> !status[3]);

  always @(negedge clk)
    p_bank_out_r8: assert (bankSel == status[6:5]);
endmodule

bind proc_status_reg proc_status_reg_chk uChk (.*);

// File: tb/tb_proc_status_reg.sv
`timescale 1ns/1ps
module tb_proc_status_reg;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [2:0] flagUpd = '0;
  logic [2:0] flagVal = '0;
  logic evtPowerUp = 1'b0, evtWdtClear = 1'b0, evtSleep = 1'b0, evtTimeout = 1'b0;
  logic [7:0] status;
  logic [1:0] bankSel;

  int checks = 0;
  int failures = 0;
  logic [7:0] expVal;
  logic [7:0] known;
  bit done = 0;

  always #2 clk = ~clk;

  proc_status_reg dut (.*);

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp,
                       input logic [7:0] mask);
    checks++;
    if ((act & mask) !== (exp & mask)) begin
      failures++;
      $display("FAIL %s: actual=%b expected=%b mask=%b", tag, act, exp, mask);
    end
  endtask

  // Bench model of one clock of the register
  function automatic logic [7:0] modelNext(input logic [7:0] cur);
    logic [7:0] n = cur;
    if (wrEn) n[7:5] = wrData[7:5];
    if (wrEn && flagUpd == 3'b000) n[2:0] = wrData[2:0];
    for (int i = 0; i < 3; i++) if (flagUpd[i]) n[i] = flagVal[i];
    if (evtPowerUp || evtWdtClear || evtSleep) n[4] = 1'b1;
    else if (evtTimeout) n[4] = 1'b0;
    if (evtPowerUp || evtWdtClear) n[3] = 1'b1;
    else if (evtSleep) n[3] = 1'b0;
    return n;
  endfunction

  function automatic logic [7:0] knownNext(input logic [7:0] k);
    logic [7:0] n = k;
    if (wrEn && flagUpd == 3'b000) n[2:0] = 3'b111;
    n[2:0] = n[2:0] | flagUpd;
    return n;
  endfunction

  function automatic string tagNow();
    if (evtPowerUp || evtWdtClear || evtSleep || evtTimeout) return "R6/R7 event";
    if (wrEn && flagUpd != 0) return "R4 masked write";
    if (wrEn) return "R2 plain write";
    if (flagUpd != 0) return "R5 flag update";
    return "R3 hold";
  endfunction

  // Inputs already driven; step one clock and compare at the next negedge
  task automatic step();
    string t = tagNow();
    expVal = modelNext(expVal);
    known = knownNext(known);
    @(negedge clk);
    check(t, status, expVal, known);
    check("R8 bank select", {6'b0, bankSel}, {6'b0, status[6:5]}, 8'hFF);
  endtask

  task automatic idle();
    wrEn = 0; flagUpd = 0; evtPowerUp = 0; evtWdtClear = 0; evtSleep = 0; evtTimeout = 0;
  endtask

  initial begin
    int seed = 32'h5a17;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    check("R1 reset value", status, 8'b0001_1000, 8'hF8);
    rstN = 1'b1;
    expVal = 8'b0001_1000;
    known = 8'hF8;
    @(negedge clk);

    // R2: plain write, all bits; bank 11 selected
    wrEn = 1; wrData = 8'hFF; flagUpd = 0; step();
    check("R2 write 0xFF", status, 8'b1111_1111, 8'hE7);
    check("R8 bank 11", {6'b0, bankSel}, 8'd3, 8'hFF);
    // R4: clear with zero-only update -> 000uu1uu
    wrData = 8'h00; flagUpd = 3'b100; flagVal = 3'b100; step();
    check("R4 clear 000uu1uu", status, 8'b0001_1111, 8'hFF);
    // R4: partial mask with carry only
    wrData = 8'b0100_0010; flagUpd = 3'b001; flagVal = 3'b000; step();
    check("R4 carry-only mask", status, 8'b0101_1110, 8'hFF);
    // R5: flag update without write
    wrEn = 0; flagUpd = 3'b111; flagVal = 3'b010; step();
    check("R5 flags no write", status, 8'b0101_1010, 8'hFF);
    // R3: write tries to clear TO/PD
    idle(); wrEn = 1; wrData = 8'h00; step();
    check("R3 TO/PD read-only", status, 8'b0001_1000, 8'h18);
    // R6: timeout, then sleep
    idle(); evtTimeout = 1; step();
    check("R6 timeout clears TO", status, 8'h00, 8'h10);
    idle(); evtSleep = 1; step();
    check("R7 sleep clears PD sets TO", status, 8'b0001_0000, 8'h18);
    idle(); evtWdtClear = 1; evtSleep = 1; step();
    check("R7 clear beats sleep", status, 8'b0001_1000, 8'h18);
    idle(); evtTimeout = 1; step();
    idle(); evtPowerUp = 1; evtTimeout = 1; step();
    check("R6 powerup beats timeout", status, 8'b0001_1000, 8'h18);
    idle(); evtSleep = 1; evtTimeout = 1; step();
    check("R6 sleep beats timeout", status, 8'b0001_0000, 8'h18);
    idle(); evtPowerUp = 1; evtSleep = 1; step();
    check("R7 powerup beats sleep", status, 8'b0001_1000, 8'h18);
    // R8: each bank value
    for (int b = 0; b < 4; b++) begin
      idle(); wrEn = 1; wrData = {1'b0, b[1:0], 5'b0}; step();
      check("R8 bank value", {6'b0, bankSel}, {6'b0, b[1:0]}, 8'hFF);
    end

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      wrEn = ($urandom % 2) == 0;
      wrData = 8'($urandom);
      flagUpd = (($urandom % 3) == 0) ? 3'($urandom) : 3'b000;
      flagVal = 3'($urandom);
      evtPowerUp = ($urandom % 16) == 0;
      evtWdtClear = ($urandom % 8) == 0;
      evtSleep = ($urandom % 8) == 0;
      evtTimeout = ($urandom % 6) == 0;
      step();
    end
    idle();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule